// File: doc/BRIEF.md
# PHY Control-Register Handshake Master

This block runs single read and write transactions into the 16-bit internal control-register space of a serial PHY. The PHY port uses a four-phase request/acknowledge handshake. A caller presents a 16-bit address, a read/write flag and, for writes, 16 bits of data. The block then steps the PHY through the whole sequence of strobes and reports the outcome with a one-cycle done or error pulse. A read also returns the sampled register value.

A transaction is made of phases. Every phase raises one strobe, waits until the acknowledge is seen high, drops the strobe and waits until the acknowledge is seen low. A read is an address phase followed by a read phase. A write is an address phase, a data phase and a commit phase. Each wait is bounded. If the PHY does not reach the awaited acknowledge level within `POLL_LIMIT` samples, the transaction is abandoned and the error pulse is given.

Top module: `phy_cr_master`

## Requirements
- R1: After reset, `busy`, `done`, `err`, all four strobes, `phy_data` and `rdata` are 0.
- R2: A command is taken only when `cmd_valid` is high while `busy` is low. `busy` is high from the next cycle. `cmd_valid` has no effect while `busy` is high.
- R3: Address phase: `phy_data` carries the address and `phy_cap_addr` is high until the acknowledge is sampled high. `phy_cap_addr` then falls while the address stays on `phy_data` until the acknowledge is sampled low.
- R4: Read: after the address phase, `phy_rd` is raised. In the cycle the acknowledge is sampled high, `phy_rdata` is stored in `rdata` and `phy_rd` falls. `done` pulses once the acknowledge is sampled low. If the acknowledge follows each strobe change after d extra cycles, `done` rises 4d+8 clock edges after the command is taken.
- R5: Write: after the address phase, a data phase with `phy_cap_data` presents `cmd_wdata`, then a commit phase pulses `phy_wr`. Each phase uses the same handshake, and the PHY sees the captured data written to the captured address. Under the delay model of R4, `done` rises 6d+12 edges after the command is taken. Afterwards every PHY-side output is 0.
- R6: At most one of the four strobes is high in any cycle.
- R7: A wait that has not seen the awaited acknowledge level after `POLL_LIMIT` (default 100) samples ends the transaction. On the edge of the last sample, all strobes drop, the block goes idle and `err` pulses. With the delay model, d = 98 still completes and d = 99 fails, with `err` 100 edges after the command is taken.
- R8: `done` and `err` are single-cycle pulses that are never high together. `busy` falls in the same cycle one of them rises.
- R9: `rdata` changes only on the read-phase acknowledge sample. A write or a failed command leaves it unchanged unless the read acknowledge was already sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Start a transaction (taken when idle) |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 16 | Register address |
| cmd_wdata | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse: transaction finished |
| err | output | 1 | One-cycle pulse: acknowledge timeout |
| rdata | output | 16 | Last value read |
| phy_data | output | 16 | Address/data lines to the PHY |
| phy_cap_addr | output | 1 | Capture-address strobe |
| phy_cap_data | output | 1 | Capture-data strobe |
| phy_wr | output | 1 | Write strobe |
| phy_rd | output | 1 | Read strobe |
| phy_ack | input | 1 | Acknowledge from the PHY |
| phy_rdata | input | 16 | Return data from the PHY |

## Verification
Every half-phase costs d+2 edges, counted from the edge that changes the strobe to the edge that samples the new acknowledge level. So `done` is due 4d+8 edges after the command edge for a read and 6d+12 for a write, and `err` is due `POLL_LIMIT` edges after the stalled wait began. The bench counts edges from the command edge and samples on falling edges. It compares the count at which `done` or `err` first appears with these formulas, then checks `rdata` and the PHY model's captured address and data in that same sample.

// File: rtl/phy_cr_master.sv
module phy_cr_master #(
  parameter int DW         = 16,
  parameter int POLL_LIMIT = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_write,
  input  logic [DW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] phy_data,
  output logic          phy_cap_addr,
  output logic          phy_cap_data,
  output logic          phy_wr,
  output logic          phy_rd,
  input  logic          phy_ack,
  input  logic [DW-1:0] phy_rdata
);
  localparam int PW = $clog2(POLL_LIMIT + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ADR_HI, S_ADR_LO, S_DAT_HI, S_DAT_LO,
    S_WR_HI, S_WR_LO, S_RD_HI, S_RD_LO
  } st_t;

  st_t           st, nxt;
  logic          is_wr;
  logic [DW-1:0] addr_q, wdata_q;
  logic [PW-1:0] polls;

  wire want_hi = (st == S_ADR_HI) || (st == S_DAT_HI) || (st == S_WR_HI) || (st == S_RD_HI);
  wire seen    = want_hi ? phy_ack : !phy_ack;
  wire expired = (polls == PW'(POLL_LIMIT - 1));

  always_comb begin
    case (st)
      S_ADR_HI: nxt = S_ADR_LO;
      S_ADR_LO: nxt = is_wr ? S_DAT_HI : S_RD_HI;
      S_DAT_HI: nxt = S_DAT_LO;
      S_DAT_LO: nxt = S_WR_HI;
      S_WR_HI:  nxt = S_WR_LO;
      S_RD_HI:  nxt = S_RD_LO;
      default:  nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      is_wr   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      polls   <= '0;
      rdata   <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (st == S_IDLE) begin
        polls <= '0;
        if (cmd_valid) begin
          st      <= S_ADR_HI;
          is_wr   <= cmd_write;
          addr_q  <= cmd_addr;
          wdata_q <= cmd_wdata;
        end
      end else if (seen) begin
        st    <= nxt;
        polls <= '0;
        if (st == S_RD_HI) rdata <= phy_rdata;
        if (nxt == S_IDLE) done <= 1'b1;
      end else if (expired) begin
        st    <= S_IDLE;
        polls <= '0;
        err   <= 1'b1;
      end else begin
        polls <= polls + 1'b1;
      end
    end
  end

  assign busy         = (st != S_IDLE);
  assign phy_cap_addr = (st == S_ADR_HI);
  assign phy_cap_data = (st == S_DAT_HI);
  assign phy_wr       = (st == S_WR_HI);
  assign phy_rd       = (st == S_RD_HI);
  assign phy_data     = (st == S_ADR_HI || st == S_ADR_LO) ? addr_q :
                        (st == S_DAT_HI || st == S_DAT_LO || st == S_WR_LO) ? wdata_q : '0;
endmodule

// File: rtl/phy_cr_master_chk.sv
module phy_cr_master_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic [DW-1:0] rdata,
  input logic [DW-1:0] phy_data,
  input logic          phy_cap_addr,
  input logic          phy_cap_data,
  input logic          phy_wr,
  input logic          phy_rd,
  input logic          phy_ack
);
  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({phy_cap_addr, phy_cap_data, phy_wr, phy_rd}));

  assert_pulse_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  assert_busy_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || err));

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid) |=> busy);

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_cap_addr && $past(phy_cap_addr)) |-> $stable(phy_data));

  assert_strobe_until_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_cap_addr && !phy_ack) |=> (phy_cap_addr || err));

  assert_rdata_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata) |-> $past(phy_rd && phy_ack));

  assert_err_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && phy_data == '0));
endmodule

bind phy_cr_master phy_cr_master_chk #(.DW(DW)) u_chk (.*);

// File: tb/tb_phy_cr_master.sv
module tb_phy_cr_master;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmd_valid = 0, cmd_write = 0;
  logic [15:0] cmd_addr = 0, cmd_wdata = 0;
  logic        busy, done, err;
  logic [15:0] rdata, phy_data, phy_rdata;
  logic        phy_cap_addr, phy_cap_data, phy_wr, phy_rd;
  logic        ack;

  always #4 clk = ~clk;

  phy_cr_master dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
    .err(err), .rdata(rdata), .phy_data(phy_data), .phy_cap_addr(phy_cap_addr),
    .phy_cap_data(phy_cap_data), .phy_wr(phy_wr), .phy_rd(phy_rd),
    .phy_ack(ack), .phy_rdata(phy_rdata));

  // PHY model: acknowledge follows the strobes after dly extra cycles
  int          dly = 0;
  bit          stuck_lo = 0, stuck_hi = 0;
  int          cnt = 0, nwr = 0;
  logic [15:0] cap_a, cap_d;
  logic [15:0] mem [16];
  wire         any = phy_cap_addr | phy_cap_data | phy_wr | phy_rd;
  assign phy_rdata = mem[cap_a[3:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      ack <= 0; cnt <= 0; cap_a <= 0; cap_d <= 0; nwr <= 0;
      for (int i = 0; i < 16; i++) mem[i] <= 16'(i * 16'h1111);
    end else if (any != ack) begin
      if ((any && stuck_lo) || (!any && stuck_hi)) cnt <= 0;
      else if (cnt >= dly) begin
        ack <= any; cnt <= 0;
        if (phy_cap_addr) cap_a <= phy_data;
        if (phy_cap_data) cap_d <= phy_data;
        if (phy_wr) begin mem[cap_a[3:0]] <= cap_d; nwr <= nwr + 1; end
      end else cnt <= cnt + 1;
    end else cnt <= 0;
  end

  int tests = 0, fails = 0;
  logic [15:0] exp_mem [16];
  logic [15:0] exp_rd = 0;

  function automatic int exp_lat(bit wr, int d);
    return wr ? 6 * d + 12 : 4 * d + 8;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(bit wr, logic [15:0] a, logic [15:0] wd, int d, bit meddle,
                     output int n, output bit got_err);
    int nw0;
    dly = d;
    nw0 = nwr;
    @(negedge clk);
    cmd_valid = 1; cmd_write = wr; cmd_addr = a; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 0;
    chk(busy, "R2 busy after accept", busy, 1);
    n = 0;
    while (!done && !err && n < 5000) begin
      if (meddle && n == 3) begin cmd_valid = 1; cmd_write = 1; cmd_addr = ~a; end
      if (n == 4) cmd_valid = 0;
      @(negedge clk);
      n++;
    end
    cmd_valid = 0;
    got_err = err;
    if (!err) begin
      chk(!busy, "R8 busy low with done", busy, 0);
      chk({phy_cap_addr, phy_cap_data, phy_wr, phy_rd, phy_data} == 0,
          wr ? "R5 lines zero at end" : "R4 lines zero at end", phy_data, 0);
      chk(cap_a == a, "R3 captured address", cap_a, a);
      if (wr) begin
        chk(cap_d == wd, "R5 captured data", cap_d, wd);
        chk(nwr == nw0 + 1, "R5 one write commit", nwr - nw0, 1);
        exp_mem[a[3:0]] = wd;
        chk(n == exp_lat(1, d), "R5 write latency", n, exp_lat(1, d));
        chk(rdata == exp_rd, "R9 rdata kept on write", rdata, exp_rd);
      end else begin
        exp_rd = exp_mem[a[3:0]];
        chk(nwr == nw0, "R4 no commit on read", nwr - nw0, 0);
        chk(rdata == exp_rd, "R4 read data", rdata, exp_rd);
        chk(n == exp_lat(0, d), "R4 read latency", n, exp_lat(0, d));
      end
      @(negedge clk);
      chk(!done, "R8 done single cycle", done, 0);
      if (meddle) begin
        chk(!busy && nwr == nw0 + (wr ? 1 : 0), "R2 command while busy ignored", busy, 0);
      end
    end
  endtask

  initial begin
    int n;
    bit e;
    for (int i = 0; i < 16; i++) exp_mem[i] = 16'(i * 16'h1111);
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk({busy, done, err, phy_cap_addr, phy_cap_data, phy_wr, phy_rd} == 0 &&
        phy_data == 0 && rdata == 0, "R1 reset state", {busy, done, err}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy, "R1 idle after reset", busy, 0);

    run(0, 16'h1005, 0, 0, 0, n, e);
    run(1, 16'h0013, 16'hBEEF, 0, 0, n, e);
    run(0, 16'h0013, 0, 2, 0, n, e);
    run(0, 16'h00A3, 0, 1, 1, n, e);
    run(1, 16'h00A4, 16'h1234, 3, 1, n, e);

    for (int k = 0; k < 60; k++) begin
      run(1'($urandom), 16'($urandom), 16'($urandom), int'($urandom % 7), 0, n, e);
      chk(!e, "R7 no timeout on prompt PHY", e, 0);
    end

    // boundary: slowest acknowledge that still fits the poll limit
    run(0, 16'h0013, 0, 98, 0, n, e);
    chk(!e, "R7 d=98 completes", e, 0);

    // d=99: first wait expires
    run(1, 16'h0042, 16'h5555, 99, 0, n, e);
    chk(e, "R7 d=99 times out", e, 1);
    chk(n == 100, "R7 timeout latency", n, 100);
    chk(!busy && !any && phy_data == 0, "R7 strobes dropped on error", any, 0);
    chk(!done, "R8 no done with err", done, 0);
    chk(rdata == exp_rd, "R9 rdata kept on error", rdata, exp_rd);
    @(negedge clk);
    chk(!err, "R8 err single cycle", err, 0);
    dly = 0;
    while (ack) @(negedge clk);

    // acknowledge never falls after address capture
    stuck_hi = 1;
    run(0, 16'h0007, 0, 0, 0, n, e);
    chk(e && n == 102, "R7 stuck-high timeout latency", n, 102);
    stuck_hi = 0;
    while (ack) @(negedge clk);

    // acknowledge never rises
    stuck_lo = 1;
    run(0, 16'h0008, 0, 0, 0, n, e);
    chk(e && n == 100, "R7 stuck-low timeout latency", n, 100);
    stuck_lo = 0;
    repeat (2) @(negedge clk);
    run(0, 16'h0013, 0, 0, 0, n, e);
    chk(!e, "R7 recovers after error", e, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule